// File: doc/BRIEF.md
# Initiator Bus Phase Sequencer

This block is the initiator side of a shared parallel peripheral bus that carries up to eight devices. Given a start request and a target ID, it waits for the bus to be idle, competes for ownership by placing its own ID bit on the data lines, and then selects the target. After that it acts as a slave to the phases the target announces. It sends an identify message and the command bytes. It moves data in either direction. It takes the status byte and reacts to incoming messages.

The target chooses each phase with three lines and paces every byte with a request/acknowledge handshake. The host side is kept minimal. Command bytes and outgoing data are fetched at pointer positions that the block publishes. Incoming bytes leave on a strobe. A target may break the connection in the middle of a transfer and come back later through reselection, and the data pointer survives that.

Top module: `phase_seq_top`

## Requirements
- R1: After reset, bsyOut, selOut, ackOut, dataOe, rxStrobe and done are all low.
- R2: After start, bsyOut rises only once bsyIn and selIn have both been low for FREE_CYC consecutive clocks (default 2). While bsyOut is high the block drives its own ID bit (bit OWN_ID, default 6) onto the data lines.
- R3: Priority is fixed by ID, and ID 7 is the highest. If the bus shows any ID bit above OWN_ID during the arbitration clock, the block drops bsyOut, never raises selOut, and waits for the bus to be free again. Lower ID bits do not stop it winning.
- R4: After winning, the block raises selOut with bsyOut low and drives its own bit OR the target bit on the data lines. It holds this until the target raises bsyIn, then drops selOut.
- R5: The phase is {phMsg,phCd,phIo}: 000 data out, 001 data in, 010 command, 011 status, 110 message out, 111 message in.
- R6: ackOut rises only on a clock where reqIn is high and ackOut is low. It falls only when reqIn is low. A new request is not served while ackOut is still high.
- R7: In the phases with phIo=0 the block drives dataOe with valid data while ackOut is high. It never drives the data lines in a transfer phase with phIo=1.
- R8: In message out the block sends the identify byte 0x80. In command phase it sends cmdByte for the current cmdPtr, and cmdPtr advances by one per byte.
- R9: In data in, each byte appears on rxByte with a one-clock rxStrobe, in the clock after ackOut falls. In data out, the byte sent is outByte for the current dataPtr. dataPtr advances by one per data byte in both directions.
- R10: A byte received in status phase is held on statusByte.
- R11: Message-in codes: 0x00 pulses done for one clock and ends the command. 0x02 saves dataPtr. 0x03 sets dataPtr back to the saved value. Codes 0x80 to 0xFF (identify) change neither dataPtr nor done.
- R12: Message-in 0x04 saves dataPtr and makes the block ignore reqIn. It resumes when it sees selIn and phIo high with the data lines equal to its own bit OR the target bit; it then restores dataPtr and serves phases again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command to tgtId |
| tgtId | input | 3 | Target device ID |
| bsyIn | input | 1 | Bus busy line as seen on the bus |
| selIn | input | 1 | Select line as seen on the bus |
| reqIn | input | 1 | Target byte request |
| phMsg | input | 1 | Phase line: message |
| phCd | input | 1 | Phase line: control/data |
| phIo | input | 1 | Phase line: direction (1 = towards initiator) |
| dataIn | input | 8 | Data lines as seen on the bus |
| dataOut | output | 8 | Value driven onto the data lines |
| dataOe | output | 1 | Data line drive enable |
| bsyOut | output | 1 | Busy drive during arbitration |
| selOut | output | 1 | Select drive during selection |
| ackOut | output | 1 | Byte acknowledge |
| cmdByte | input | 8 | Host command byte at cmdPtr |
| cmdPtr | output | 4 | Index of next command byte |
| outByte | input | 8 | Host data byte at dataPtr |
| dataPtr | output | 8 | Current data pointer |
| rxStrobe | output | 1 | Received data byte valid |
| rxByte | output | 8 | Received data byte |
| statusByte | output | 8 | Last status byte |
| done | output | 1 | Command complete pulse |

## Verification
On every clock the assertions check three things. Ownership is taken only from an idle bus. Selection follows only an arbitration clock with no higher ID bit on the bus. The acknowledge edges obey the request line. They also check that the block leaves the data lines alone in inbound transfer phases and that rxStrobe and done follow an acknowledge release. Only the bench scenarios can show the rest. Those are the exact number of idle clocks before arbitration, losing to ID 7 and retrying later, the byte values in each phase, and the pointer being saved and restored across a disconnect and reselection. They also cover message codes that must have no effect.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_FREE, ST_ARB, ST_SEL, ST_XFER, ST_RESEL} seqState_t;
  typedef enum logic [2:0] {DRV_NONE, DRV_ARB, DRV_SEL, DRV_CMD, DRV_DATA, DRV_IDENT} drvSel_t;

  typedef struct packed {
    logic    newCmd;
    logic    latchRx;
    logic    stepData;
    logic    stepCmd;
    logic    pushRx;
    logic    takeStatus;
    logic    savePtr;
    logic    restorePtr;
    drvSel_t drv;
  } seqStrobe_t;

  // phase code {msg, cd, io}
  localparam logic [2:0] PH_DOUT = 3'b000;
  localparam logic [2:0] PH_DIN  = 3'b001;
  localparam logic [2:0] PH_CMD  = 3'b010;
  localparam logic [2:0] PH_STAT = 3'b011;
  localparam logic [2:0] PH_MOUT = 3'b110;
  localparam logic [2:0] PH_MIN  = 3'b111;

  localparam logic [7:0] MSG_DONE    = 8'h00;
  localparam logic [7:0] MSG_SAVE    = 8'h02;
  localparam logic [7:0] MSG_RESTORE = 8'h03;
  localparam logic [7:0] MSG_DISC    = 8'h04;
  localparam logic [7:0] MSG_IDENT   = 8'h80;
endpackage

// File: rtl/phase_seq_ctrl.sv
module phase_seq_ctrl
  import phase_seq_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int FREE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             bsyIn,
  input  logic             selIn,
  input  logic             reqIn,
  input  logic             phMsg,
  input  logic             phCd,
  input  logic             phIo,
  input  logic             higherSeen,
  input  logic             reselMatch,
  input  logic [BUS_W-1:0] rxReg,
  output seqStrobe_t       strobe,
  output logic             bsyOut,
  output logic             selOut,
  output logic             ackOut,
  output logic             done
);
  localparam int CNT_W = $clog2(FREE_CYC) + 1;

  seqState_t        state;
  logic [CNT_W-1:0] freeCnt;
  logic [2:0]       phase;
  logic             busFree, reqSeen, reqDone;

  assign phase   = {phMsg, phCd, phIo};
  assign busFree = !bsyIn && !selIn;
  assign reqSeen = (state == ST_XFER) && reqIn && !ackOut;
  assign reqDone = (state == ST_XFER) && !reqIn && ackOut;
  assign bsyOut  = (state == ST_ARB);
  assign selOut  = (state == ST_SEL);

  always_comb begin
    strobe         = '0;
    strobe.drv     = DRV_NONE;
    strobe.newCmd  = (state == ST_IDLE) && start;
    strobe.latchRx = reqSeen;
    if (reqDone) begin
      case (phase)
        PH_DOUT: strobe.stepData = 1'b1;
        PH_DIN: begin
          strobe.stepData = 1'b1;
          strobe.pushRx   = 1'b1;
        end
        PH_CMD:  strobe.stepCmd    = 1'b1;
        PH_STAT: strobe.takeStatus = 1'b1;
        PH_MIN: begin
          if (rxReg == BUS_W'(MSG_SAVE) || rxReg == BUS_W'(MSG_DISC)) strobe.savePtr = 1'b1;
          if (rxReg == BUS_W'(MSG_RESTORE)) strobe.restorePtr = 1'b1;
        end
        default: ;
      endcase
    end
    if (state == ST_RESEL && reselMatch) strobe.restorePtr = 1'b1;
    case (state)
      ST_ARB: strobe.drv = DRV_ARB;
      ST_SEL: strobe.drv = DRV_SEL;
      ST_XFER: begin
        if (!phIo) begin
          if (phMsg) strobe.drv = phCd ? DRV_IDENT : DRV_NONE;
          else       strobe.drv = phCd ? DRV_CMD : DRV_DATA;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      freeCnt <= '0;
      ackOut  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_FREE;
          freeCnt <= '0;
        end
        ST_FREE: begin
          if (busFree) begin
            if (freeCnt == CNT_W'(FREE_CYC - 1)) begin
              state   <= ST_ARB;
              freeCnt <= '0;
            end else begin
              freeCnt <= freeCnt + 1'b1;
            end
          end else begin
            freeCnt <= '0;
          end
        end
        ST_ARB:  state <= higherSeen ? ST_FREE : ST_SEL;
        ST_SEL:  if (bsyIn) state <= ST_XFER;
        ST_XFER: begin
          if (reqSeen) ackOut <= 1'b1;
          if (reqDone) begin
            ackOut <= 1'b0;
            if (phase == PH_MIN) begin
              if (rxReg == BUS_W'(MSG_DONE)) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else if (rxReg == BUS_W'(MSG_DISC)) begin
                state <= ST_RESEL;
              end
            end
          end
        end
        ST_RESEL: if (reselMatch) state <= ST_XFER;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_seq_datapath.sv
module phase_seq_datapath
  import phase_seq_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int OWN_ID = 6,
  parameter int PTR_W  = 8,
  parameter int CMD_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [$clog2(BUS_W)-1:0] tgtIdIn,
  input  logic [BUS_W-1:0]         dataIn,
  input  logic                     selIn,
  input  logic                     phIo,
  input  logic [BUS_W-1:0]         cmdByte,
  input  logic [BUS_W-1:0]         outByte,
  output logic [BUS_W-1:0]         dataOut,
  output logic                     dataOe,
  output logic                     higherSeen,
  output logic                     reselMatch,
  output logic [BUS_W-1:0]         rxReg,
  output logic                     rxStrobe,
  output logic [BUS_W-1:0]         rxByte,
  output logic [BUS_W-1:0]         statusByte,
  output logic [PTR_W-1:0]         dataPtr,
  output logic [CMD_W-1:0]         cmdPtr
);
  localparam int ID_W = $clog2(BUS_W);
  localparam logic [BUS_W-1:0] OWN_BIT   = BUS_W'(1) << OWN_ID;
  localparam logic [BUS_W-1:0] HIGH_MASK = ~((OWN_BIT << 1) - BUS_W'(1));

  logic [ID_W-1:0]  tgtReg;
  logic [PTR_W-1:0] savedPtr;
  logic [BUS_W-1:0] tgtBit;

  assign tgtBit     = BUS_W'(1) << tgtReg;
  assign higherSeen = |(dataIn & HIGH_MASK);
  assign reselMatch = selIn && phIo && (dataIn == (OWN_BIT | tgtBit));
  assign dataOe     = (strobe.drv != DRV_NONE);

  always_comb begin
    case (strobe.drv)
      DRV_ARB:   dataOut = OWN_BIT;
      DRV_SEL:   dataOut = OWN_BIT | tgtBit;
      DRV_CMD:   dataOut = cmdByte;
      DRV_DATA:  dataOut = outByte;
      DRV_IDENT: dataOut = BUS_W'(MSG_IDENT);
      default:   dataOut = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtReg     <= '0;
      dataPtr    <= '0;
      savedPtr   <= '0;
      cmdPtr     <= '0;
      rxReg      <= '0;
      rxStrobe   <= 1'b0;
      rxByte     <= '0;
      statusByte <= '0;
    end else begin
      rxStrobe <= 1'b0;
      if (strobe.newCmd) begin
        tgtReg   <= tgtIdIn;
        dataPtr  <= '0;
        savedPtr <= '0;
        cmdPtr   <= '0;
      end
      if (strobe.latchRx)    rxReg <= dataIn;
      if (strobe.stepData)   dataPtr <= dataPtr + 1'b1;
      if (strobe.stepCmd)    cmdPtr <= cmdPtr + 1'b1;
      if (strobe.pushRx) begin
        rxStrobe <= 1'b1;
        rxByte   <= rxReg;
      end
      if (strobe.takeStatus) statusByte <= rxReg;
      if (strobe.savePtr)    savedPtr <= dataPtr;
      if (strobe.restorePtr) dataPtr <= savedPtr;
    end
  end
endmodule

// File: rtl/phase_seq_top.sv
module phase_seq_top
  import phase_seq_pkg::*;
#(
  parameter int NUM_IDS  = 8,
  parameter int OWN_ID   = 6,
  parameter int FREE_CYC = 2,
  parameter int PTR_W    = 8,
  parameter int CMD_W    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [$clog2(NUM_IDS)-1:0] tgtId,
  input  logic                       bsyIn,
  input  logic                       selIn,
  input  logic                       reqIn,
  input  logic                       phMsg,
  input  logic                       phCd,
  input  logic                       phIo,
  input  logic [NUM_IDS-1:0]         dataIn,
  output logic [NUM_IDS-1:0]         dataOut,
  output logic                       dataOe,
  output logic                       bsyOut,
  output logic                       selOut,
  output logic                       ackOut,
  input  logic [NUM_IDS-1:0]         cmdByte,
  output logic [CMD_W-1:0]           cmdPtr,
  input  logic [NUM_IDS-1:0]         outByte,
  output logic [PTR_W-1:0]           dataPtr,
  output logic                       rxStrobe,
  output logic [NUM_IDS-1:0]         rxByte,
  output logic [NUM_IDS-1:0]         statusByte,
  output logic                       done
);
  localparam int BUS_W = NUM_IDS;

  seqStrobe_t       strobe;
  logic             higherSeen, reselMatch;
  logic [BUS_W-1:0] rxReg;

  phase_seq_ctrl #(.BUS_W(BUS_W), .FREE_CYC(FREE_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .bsyIn(bsyIn), .selIn(selIn),
    .reqIn(reqIn), .phMsg(phMsg), .phCd(phCd), .phIo(phIo),
    .higherSeen(higherSeen), .reselMatch(reselMatch), .rxReg(rxReg),
    .strobe(strobe), .bsyOut(bsyOut), .selOut(selOut), .ackOut(ackOut), .done(done)
  );

  phase_seq_datapath #(.BUS_W(BUS_W), .OWN_ID(OWN_ID), .PTR_W(PTR_W), .CMD_W(CMD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtIdIn(tgtId), .dataIn(dataIn),
    .selIn(selIn), .phIo(phIo), .cmdByte(cmdByte), .outByte(outByte),
    .dataOut(dataOut), .dataOe(dataOe), .higherSeen(higherSeen), .reselMatch(reselMatch),
    .rxReg(rxReg), .rxStrobe(rxStrobe), .rxByte(rxByte), .statusByte(statusByte),
    .dataPtr(dataPtr), .cmdPtr(cmdPtr)
  );
endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk #(
  parameter int BUS_W  = 8,
  parameter int OWN_ID = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             bsyIn,
  input logic             selIn,
  input logic             reqIn,
  input logic             phIo,
  input logic             bsyOut,
  input logic             selOut,
  input logic             ackOut,
  input logic             dataOe,
  input logic             rxStrobe,
  input logic             done,
  input logic [BUS_W-1:0] dataIn
);
  localparam logic [BUS_W-1:0] OWN_BIT   = BUS_W'(1) << OWN_ID;
  localparam logic [BUS_W-1:0] HIGH_MASK = ~((OWN_BIT << 1) - BUS_W'(1));

  a_r2_arb_from_free: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bsyOut) |-> $past(!bsyIn && !selIn));

  a_r3_sel_after_win: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selOut) |-> ($past(bsyOut) && (($past(dataIn) & HIGH_MASK) == '0)));

  a_r4_sel_without_bsy: assert property (@(posedge clk) disable iff (!rstN)
    selOut |-> !bsyOut);

  a_r6_ack_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(reqIn));

  a_r6_ack_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> !$past(reqIn));

  a_r7_out_valid: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && !phIo) |-> dataOe);

  a_r7_no_drive_in: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && phIo) |-> !dataOe);

  a_r9_rx_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> $fell(ackOut));

  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(ackOut));
endmodule

bind phase_seq_top phase_seq_chk #(.BUS_W(NUM_IDS), .OWN_ID(OWN_ID)) chk_i (
  .clk(clk), .rstN(rstN), .bsyIn(bsyIn), .selIn(selIn), .reqIn(reqIn), .phIo(phIo),
  .bsyOut(bsyOut), .selOut(selOut), .ackOut(ackOut), .dataOe(dataOe),
  .rxStrobe(rxStrobe), .done(done), .dataIn(dataIn)
);

// File: tb/phase_seq_top_tb_top.sv
module phase_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OWN = 6;
  localparam int FREE = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [2:0] tgtId = '0;
  logic       bsyIn = 1'b0, selIn = 1'b0, reqIn = 1'b0;
  logic       phMsg = 1'b0, phCd = 1'b0, phIo = 1'b0;
  logic [7:0] tgtData = '0;
  logic       compOn = 1'b0;
  logic [2:0] compId = '0;
  logic [7:0] arbBits, busData, dataOut, cmdByte, outByte, rxByte, statusByte, dataPtr;
  logic [3:0] cmdPtr;
  logic       dataOe, bsyOut, selOut, ackOut, rxStrobe, done;

  int total = 0;
  int bad = 0;
  int rxCount = 0;
  int doneCount = 0;
  logic [7:0] rxLog [64];
  logic [7:0] expIn [8];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign arbBits = (compOn && bsyOut) ? (8'd1 << compId) : 8'd0;
  assign busData = (dataOe ? dataOut : 8'h00) | tgtData | arbBits;
  assign cmdByte = 8'hC0 + {4'h0, cmdPtr};
  assign outByte = dataPtr * 8'd3 + 8'h21;

  phase_seq_top #(.NUM_IDS(8), .OWN_ID(OWN), .FREE_CYC(FREE), .PTR_W(8), .CMD_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .tgtId(tgtId), .bsyIn(bsyIn), .selIn(selIn),
    .reqIn(reqIn), .phMsg(phMsg), .phCd(phCd), .phIo(phIo), .dataIn(busData),
    .dataOut(dataOut), .dataOe(dataOe), .bsyOut(bsyOut), .selOut(selOut), .ackOut(ackOut),
    .cmdByte(cmdByte), .cmdPtr(cmdPtr), .outByte(outByte), .dataPtr(dataPtr),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .statusByte(statusByte), .done(done)
  );

  always @(negedge clk) begin
    if (rxStrobe) begin
      if (rxCount < 64) rxLog[rxCount] = rxByte;
      rxCount++;
    end
    if (done) doneCount++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // target side of one byte handshake; returns bus value seen while ACK is high
  task automatic xferByte(input logic [2:0] ph, input logic [7:0] tByte, output logic [7:0] seen);
    bit got = 0;
    {phMsg, phCd, phIo} = ph;
    tgtData = ph[0] ? tByte : 8'h00;
    reqIn = 1'b1;
    seen = 8'h00;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (ackOut) got = 1;
    end
    check(got, "R6 ack timeout", 0, 1);
    seen = busData;
    if (!ph[0]) check(dataOe, "R7 drive with ack", dataOe, 1);
    else        check(!dataOe, "R7 no drive inbound", dataOe, 0);
    reqIn = 1'b0;
    tgtData = 8'h00;
    got = 0;
    for (int k = 0; k < 40 && !got; k++) begin
      @(negedge clk);
      if (!ackOut) got = 1;
    end
    check(got, "R6 ack release", 1, 0);
  endtask

  task automatic waitBsy(output int n);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      n++;
      if (bsyOut) break;
    end
  endtask

  task automatic runCmd(input int tgt, input int comp, input bit dirIn, input bit withDisc);
    logic [7:0] seen;
    logic [7:0] tBit;
    int n;
    int dc;
    int rx0;
    tBit = 8'd1 << tgt;
    rx0 = rxCount;
    dc = doneCount;
    bsyIn = 1'b1;
    @(negedge clk);
    tgtId = tgt[2:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    compOn = (comp >= 0);
    compId = comp[2:0];
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!bsyOut, "R2 busy bus blocks arbitration", bsyOut, 0);
    end
    bsyIn = 1'b0;
    waitBsy(n);
    check(n == FREE, "R2 idle clocks before arbitration", n, FREE);
    check(busData == ((8'd1 << OWN) | arbBits), "R2 own id on bus", busData, (8'd1 << OWN) | arbBits);
    if (comp > OWN) begin
      bsyIn = 1'b1;
      @(negedge clk);
      check(!selOut && !bsyOut, "R3 lose to higher id", {selOut, bsyOut}, 0);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check(!bsyOut && !selOut, "R3 stays off while other owns bus", {selOut, bsyOut}, 0);
      end
      compOn = 1'b0;
      bsyIn = 1'b0;
      waitBsy(n);
      check(n == FREE, "R3 retry after bus free", n, FREE);
    end
    @(negedge clk);
    check(selOut && !bsyOut, "R4 selection after win", {selOut, bsyOut}, 2);
    check(busData == ((8'd1 << OWN) | tBit), "R4 selection ids", busData, (8'd1 << OWN) | tBit);
    compOn = 1'b0;
    @(negedge clk);
    check(selOut, "R4 select held", selOut, 1);
    bsyIn = 1'b1;
    @(negedge clk);
    check(!selOut, "R4 select dropped", selOut, 0);

    xferByte(3'b110, 8'h00, seen);
    check(seen == 8'h80, "R8 identify out", seen, 8'h80);
    for (int i = 0; i < 3; i++) begin
      xferByte(3'b010, 8'h00, seen);
      check(seen == 8'hC0 + i, "R8 command byte", seen, 8'hC0 + i);
    end
    check(cmdPtr == 4'd3, "R8 command pointer", cmdPtr, 3);

    for (int i = 0; i < 6; i++) begin
      if (i == 2 && withDisc) begin
        xferByte(3'b111, 8'h04, seen);
        bsyIn = 1'b0;
        {phMsg, phCd, phIo} = dirIn ? 3'b001 : 3'b000;
        reqIn = 1'b1;
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          check(!ackOut, "R12 request ignored while disconnected", ackOut, 0);
        end
        reqIn = 1'b0;
        @(negedge clk);
        selIn = 1'b1;
        phIo = 1'b1;
        tgtData = (8'd1 << OWN) | tBit;
        @(negedge clk);
        selIn = 1'b0;
        tgtData = 8'h00;
        bsyIn = 1'b1;
        @(negedge clk);
        check(dataPtr == 8'd2, "R12 pointer after reselection", dataPtr, 2);
      end
      if (i == 4) begin
        xferByte(3'b111, 8'h02, seen);
        xferByte(3'b111, 8'h85, seen);
        @(negedge clk);
        check(dataPtr == 8'd4, "R11 identify in has no effect", dataPtr, 4);
      end
      expIn[i] = 8'h50 + 8'(i * 7 + tgt);
      xferByte(dirIn ? 3'b001 : 3'b000, expIn[i], seen);
      if (!dirIn) check(seen == 8'(i * 3 + 8'h21), "R9 data out byte", seen, i * 3 + 8'h21);
    end
    check(dataPtr == 8'd6, "R9 pointer advance", dataPtr, 6);
    xferByte(3'b111, 8'h03, seen);
    check(dataPtr == 8'd4, "R11 restore pointer", dataPtr, 4);

    @(negedge clk);
    if (dirIn) begin
      check(rxCount - rx0 == 6, "R9 received count", rxCount - rx0, 6);
      for (int i = 0; i < 6; i++)
        check(rxLog[rx0 + i] == expIn[i], "R9 received byte", rxLog[rx0 + i], expIn[i]);
    end else begin
      check(rxCount == rx0, "R9 no strobe on data out", rxCount - rx0, 0);
    end

    xferByte(3'b011, 8'h10 + 8'(tgt), seen);
    check(statusByte == 8'h10 + 8'(tgt), "R10 status byte", statusByte, 8'h10 + tgt);
    check(doneCount == dc, "R11 no done before complete", doneCount - dc, 0);
    xferByte(3'b111, 8'h00, seen);
    @(negedge clk);
    check(doneCount == dc + 1, "R11 done pulse", doneCount - dc, 1);
    bsyIn = 1'b0;
    {phMsg, phCd, phIo} = 3'b000;
    @(negedge clk);
    check(!bsyOut && !selOut && !ackOut && !dataOe, "R11 idle after complete",
          {bsyOut, selOut, ackOut, dataOe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bsyOut && !selOut && !ackOut && !dataOe && !rxStrobe && !done, "R1 reset outputs",
          {bsyOut, selOut, ackOut, dataOe, rxStrobe, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!bsyOut && !selOut && !ackOut && !dataOe, "R1 idle after reset",
          {bsyOut, selOut, ackOut, dataOe}, 0);
    // R5 phase codes exercised: 110 out msg, 010 command, 000/001 data, 011 status, 111 in msg
    runCmd(3, -1, 1'b1, 1'b0);
    for (int c = 0; c < 8; c++) begin
      if (c != OWN) begin
        int t;
        t = (c + 3) % 8;
        if (t == OWN) t = 1;
        runCmd(t, c, c[0], (c % 3) == 0);
      end
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule